// File: doc/BRIEF.md
# Multicycle Processor Controller with Exception Arcs

This block is the state-machine controller of a multicycle processor that runs six instruction kinds: load word, store word, register-register ALU operations, OR with an unsigned immediate, branch on equal and jump. Each instruction moves through a fixed sequence of states. In every state the controller drives the strobes that the datapath needs for that cycle: PC write and PC source, instruction and operand latch loads, register-file and memory enables, ALU operand and function selects, and the exception-PC and cause writes.

Two conditions leave the normal sequence. An opcode outside the six known ones is caught in the decode state and goes to an undefined-instruction trap state. An overflow reported by the ALU during the register-register execute cycle goes to an overflow trap state instead of writeback. Both trap states save PC minus 4 as the exception PC, write a cause code and steer PC to a fixed handler entry. They write neither the register file nor memory, so the faulting instruction changes no architectural state. Every sequence, trap or normal, returns to instruction fetch.

The datapath, the register file, memory and the handler code lie outside the block. `opcode` is the opcode field of the instruction register. The two ALU flags come from the datapath ALU.

Top module: `mcycle_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the controller enters the fetch step. This holds also when reset arrives in the middle of an instruction.
- R2: Fetch step: `memRead`=1, `irLoad`=1, `pcWrite`=1, `pcSrc`=0 (incremented PC), `aluSrcA`=0 (PC), `aluSrcB`=1 (constant 4), `aluOp`=0 (add). Every strobe that a step does not list is 0.
- R3: The step after fetch is always decode: `abLoad`=1, `aluSrcA`=0, `aluSrcB`=3 (sign-extended offset shifted left by 2), `aluOp`=0.
- R4: Load (opcode 0x23) runs fetch, decode, then three steps. Address step: `aluSrcA`=1 (A), `aluSrcB`=2 (sign-extended), `aluOp`=0. Read step: `memRead`=1, `iord`=1. Writeback step: `regWrite`=1, `memToReg`=1, `regDst`=0 (rt).
- R5: Store (opcode 0x2B) runs fetch, decode, the address step of R4, then a write step with `memWrite`=1 and `iord`=1. That is 4 steps in total.
- R6: Register-register (opcode 0x00) runs fetch and decode. The execute step follows with `aluSrcA`=1, `aluSrcB`=0 (B), `aluOp`=3 (function field). When `aluOverflow` is low, a writeback step follows with `regWrite`=1 and `regDst`=1 (rd).
- R7: OR-immediate (opcode 0x0D) runs fetch and decode. The execute step follows with `aluSrcA`=1, `aluSrcB`=4 (zero-extended), `aluOp`=2 (OR). A writeback step follows with `regWrite`=1 and `regDst`=0.
- R8: Branch-equal (opcode 0x04) runs fetch, decode, then one step with `aluSrcA`=1, `aluSrcB`=0, `aluOp`=1 (subtract) and `pcSrc`=1 (branch target). In that step `pcWrite` equals `aluEqual`.
- R9: Jump (opcode 0x02) runs fetch, decode, then one step with `pcWrite`=1 and `pcSrc`=2 (jump target).
- R10: Any other opcode goes from decode to an undefined-instruction trap step: `epcWrite`=1, `causeWrite`=1, `causeCode`=10, `pcWrite`=1, `pcSrc`=3 (handler), and the ALU set to PC minus 4 (`aluSrcA`=0, `aluSrcB`=1, `aluOp`=1). The next step is fetch.
- R11: `aluOverflow` high in the register-register execute step leads to an overflow trap step. That step has the strobes of R10, except `causeCode`=12, and there is no writeback step. `aluOverflow` is ignored in every other step.
- R12: `regWrite` and `memWrite` are 0 in both trap steps. `causeCode` is 0 whenever `causeWrite` is 0.
- R13: `trapVector` carries the handler entry address 0x80000080.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| aluOverflow | input | 1 | ALU signed overflow flag |
| aluEqual | input | 1 | ALU result-is-zero flag |
| pcWrite | output | 1 | Load PC this cycle |
| pcSrc | output | 2 | PC source: 0 increment, 1 branch target, 2 jump target, 3 handler |
| irLoad | output | 1 | Load instruction register |
| abLoad | output | 1 | Load A and B operand latches from rs and rt |
| iord | output | 1 | Memory address source: 0 PC, 1 ALU result |
| memRead | output | 1 | Memory read |
| memWrite | output | 1 | Memory write |
| regWrite | output | 1 | Register-file write |
| regDst | output | 1 | Destination register: 0 rt, 1 rd |
| memToReg | output | 1 | Writeback data: 0 ALU result, 1 memory data |
| aluSrcA | output | 1 | ALU A input: 0 PC, 1 A latch |
| aluSrcB | output | 3 | ALU B input: 0 B latch, 1 constant 4, 2 sign-extended, 3 sign-extended shifted by 2, 4 zero-extended |
| aluOp | output | 2 | ALU function: 0 add, 1 subtract, 2 OR, 3 function field |
| epcWrite | output | 1 | Write the ALU result (PC minus 4) into the exception PC |
| causeWrite | output | 1 | Write the cause register |
| causeCode | output | 5 | Cause value, 10 undefined opcode, 12 overflow |
| trapVector | output | 32 | Handler entry address for PC source 3 |

## Verification
The assertions assume that `opcode` holds still for the whole of an instruction, as a real instruction register does between fetches. They also assume that `aluOverflow` means something only in the cycle of the register-register execute step. The bench sets opcode and both flags once before each fetch and keeps them constant until the next fetch, so the first assumption holds. It also raises the overflow flag during load and branch instructions, which must then run normally, to show that the flag matters in the execute step only.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_MEMADDR, ST_LOADRD, ST_LOADWB, ST_STORE,
    ST_REXEC, ST_RWB, ST_ORIEXEC, ST_ORIWB, ST_BRANCH, ST_JUMP,
    ST_TRAPUNDEF, ST_TRAPOVF
  } ctrlState_t;

  // order matches the opcode table in mcc_opclass
  typedef enum logic [2:0] {
    OPC_LOAD, OPC_STORE, OPC_RTYPE, OPC_ORI, OPC_BEQ, OPC_JUMP, OPC_OTHER
  } opClass_t;

  typedef enum logic [1:0] {PC_INCR, PC_TARGET, PC_JUMP, PC_TRAP} pcSel_t;
  typedef enum logic [2:0] {B_REG, B_FOUR, B_SEXT, B_SEXT_SH, B_ZEXT} aluB_t;
  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR, ALU_FUNC} aluFn_t;
  typedef enum logic [1:0] {TRAP_NONE, TRAP_UNDEF, TRAP_OVF} trapKind_t;

  typedef struct packed {
    logic      pcWrite;
    pcSel_t    pcSrc;
    logic      irLoad;
    logic      abLoad;
    logic      iord;
    logic      memRead;
    logic      memWrite;
    logic      regWrite;
    logic      regDst;
    logic      memToReg;
    logic      aluSrcA;
    aluB_t     aluSrcB;
    aluFn_t    aluOp;
    logic      epcWrite;
    trapKind_t trap;
  } strobes_t;

endpackage

// File: rtl/mcc_opclass.sv
module mcc_opclass
  import mcc_pkg::*;
#(
  parameter int OP_W = 6,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'h23,
  parameter logic [OP_W-1:0] OP_STORE = 6'h2B,
  parameter logic [OP_W-1:0] OP_RTYPE = 6'h00,
  parameter logic [OP_W-1:0] OP_ORI   = 6'h0D,
  parameter logic [OP_W-1:0] OP_BEQ   = 6'h04,
  parameter logic [OP_W-1:0] OP_JUMP  = 6'h02
) (
  input  logic [OP_W-1:0] opcode,
  output opClass_t        opClass
);

  localparam int NUM_OPS = 6;
  localparam logic [OP_W-1:0] OP_TAB [NUM_OPS] =
    '{OP_LOAD, OP_STORE, OP_RTYPE, OP_ORI, OP_BEQ, OP_JUMP};

  logic [NUM_OPS-1:0] hit;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_match
    assign hit[i] = (opcode == OP_TAB[i]);
  end

  // anything unmatched falls to the "other" class
  always_comb begin
    opClass = OPC_OTHER;
    for (int i = NUM_OPS - 1; i >= 0; i--) begin
      if (hit[i]) opClass = opClass_t'(3'(i));
    end
  end

endmodule

// File: rtl/mcc_sequencer.sv
module mcc_sequencer
  import mcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  opClass_t   opClass,
  input  logic       aluOverflow,
  output ctrlState_t state
);

  ctrlState_t nextState;

  always_comb begin
    nextState = ST_FETCH;
    unique case (state)
      ST_FETCH:  nextState = ST_DECODE;
      ST_DECODE: begin
        unique case (opClass)
          OPC_LOAD, OPC_STORE: nextState = ST_MEMADDR;
          OPC_RTYPE:           nextState = ST_REXEC;
          OPC_ORI:             nextState = ST_ORIEXEC;
          OPC_BEQ:             nextState = ST_BRANCH;
          OPC_JUMP:            nextState = ST_JUMP;
          default:             nextState = ST_TRAPUNDEF;
        endcase
      end
      ST_MEMADDR: nextState = (opClass == OPC_STORE) ? ST_STORE : ST_LOADRD;
      ST_LOADRD:  nextState = ST_LOADWB;
      ST_REXEC:   nextState = aluOverflow ? ST_TRAPOVF : ST_RWB;
      ST_ORIEXEC: nextState = ST_ORIWB;
      default:    nextState = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= nextState;
  end

endmodule

// File: rtl/mcc_strobes.sv
module mcc_strobes
  import mcc_pkg::*;
(
  input  ctrlState_t state,
  input  logic       aluEqual,
  output strobes_t   strb
);

  always_comb begin
    strb = '0;
    unique case (state)
      ST_FETCH: begin
        strb.memRead = 1'b1;
        strb.irLoad  = 1'b1;
        strb.pcWrite = 1'b1;
        strb.pcSrc   = PC_INCR;
        strb.aluSrcB = B_FOUR;
        strb.aluOp   = ALU_ADD;
      end
      ST_DECODE: begin
        strb.abLoad  = 1'b1;
        strb.aluSrcB = B_SEXT_SH;
        strb.aluOp   = ALU_ADD;
      end
      ST_MEMADDR: begin
        strb.aluSrcA = 1'b1;
        strb.aluSrcB = B_SEXT;
        strb.aluOp   = ALU_ADD;
      end
      ST_LOADRD: begin
        strb.memRead = 1'b1;
        strb.iord    = 1'b1;
      end
      ST_LOADWB: begin
        strb.regWrite = 1'b1;
        strb.memToReg = 1'b1;
      end
      ST_STORE: begin
        strb.memWrite = 1'b1;
        strb.iord     = 1'b1;
      end
      ST_REXEC: begin
        strb.aluSrcA = 1'b1;
        strb.aluSrcB = B_REG;
        strb.aluOp   = ALU_FUNC;
      end
      ST_RWB: begin
        strb.regWrite = 1'b1;
        strb.regDst   = 1'b1;
      end
      ST_ORIEXEC: begin
        strb.aluSrcA = 1'b1;
        strb.aluSrcB = B_ZEXT;
        strb.aluOp   = ALU_OR;
      end
      ST_ORIWB: strb.regWrite = 1'b1;
      ST_BRANCH: begin
        strb.aluSrcA = 1'b1;
        strb.aluSrcB = B_REG;
        strb.aluOp   = ALU_SUB;
        strb.pcSrc   = PC_TARGET;
        strb.pcWrite = aluEqual;
      end
      ST_JUMP: begin
        strb.pcWrite = 1'b1;
        strb.pcSrc   = PC_JUMP;
      end
      ST_TRAPUNDEF, ST_TRAPOVF: begin
        // ALU forms PC - 4 for the exception PC; no register or memory write
        strb.aluSrcB  = B_FOUR;
        strb.aluOp    = ALU_SUB;
        strb.epcWrite = 1'b1;
        strb.pcWrite  = 1'b1;
        strb.pcSrc    = PC_TRAP;
        strb.trap     = (state == ST_TRAPOVF) ? TRAP_OVF : TRAP_UNDEF;
      end
      default: strb = '0;
    endcase
  end

endmodule

// File: rtl/mcycle_ctrl.sv
module mcycle_ctrl
  import mcc_pkg::*;
#(
  parameter int OP_W    = 6,
  parameter int CAUSE_W = 5,
  parameter int ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 32'h8000_0080,
  parameter int unsigned CAUSE_UNDEF = 10,
  parameter int unsigned CAUSE_OVF   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OP_W-1:0]    opcode,
  input  logic               aluOverflow,
  input  logic               aluEqual,
  output logic               pcWrite,
  output logic [1:0]         pcSrc,
  output logic               irLoad,
  output logic               abLoad,
  output logic               iord,
  output logic               memRead,
  output logic               memWrite,
  output logic               regWrite,
  output logic               regDst,
  output logic               memToReg,
  output logic               aluSrcA,
  output logic [2:0]         aluSrcB,
  output logic [1:0]         aluOp,
  output logic               epcWrite,
  output logic               causeWrite,
  output logic [CAUSE_W-1:0] causeCode,
  output logic [ADDR_W-1:0]  trapVector
);

  opClass_t   opClass;
  ctrlState_t state;
  strobes_t   strb;

  mcc_opclass #(.OP_W(OP_W)) u_opclass (
    .opcode (opcode),
    .opClass(opClass)
  );

  mcc_sequencer u_seq (
    .clk        (clk),
    .rst        (rst),
    .opClass    (opClass),
    .aluOverflow(aluOverflow),
    .state      (state)
  );

  mcc_strobes u_strb (
    .state   (state),
    .aluEqual(aluEqual),
    .strb    (strb)
  );

  assign pcWrite    = strb.pcWrite;
  assign pcSrc      = strb.pcSrc;
  assign irLoad     = strb.irLoad;
  assign abLoad     = strb.abLoad;
  assign iord       = strb.iord;
  assign memRead    = strb.memRead;
  assign memWrite   = strb.memWrite;
  assign regWrite   = strb.regWrite;
  assign regDst     = strb.regDst;
  assign memToReg   = strb.memToReg;
  assign aluSrcA    = strb.aluSrcA;
  assign aluSrcB    = strb.aluSrcB;
  assign aluOp      = strb.aluOp;
  assign epcWrite   = strb.epcWrite;
  assign causeWrite = (strb.trap != TRAP_NONE);
  assign trapVector = HANDLER_ADDR;

  always_comb begin
    unique case (strb.trap)
      TRAP_UNDEF: causeCode = CAUSE_W'(CAUSE_UNDEF);
      TRAP_OVF:   causeCode = CAUSE_W'(CAUSE_OVF);
      default:    causeCode = '0;
    endcase
  end

endmodule

// File: rtl/mcycle_ctrl_chk.sv
module mcycle_ctrl_chk #(
  parameter int CAUSE_W = 5,
  parameter int unsigned CAUSE_OVF = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               aluOverflow,
  input logic               pcWrite,
  input logic [1:0]         pcSrc,
  input logic               irLoad,
  input logic               abLoad,
  input logic               memRead,
  input logic               memWrite,
  input logic               regWrite,
  input logic               regDst,
  input logic [1:0]         aluOp,
  input logic               epcWrite,
  input logic               causeWrite,
  input logic [CAUSE_W-1:0] causeCode
);

  // R12: a trapping step changes no register or memory
  a_r12_trap_no_arch_write: assert property (@(posedge clk) disable iff (rst)
    epcWrite |-> (!regWrite && !memWrite));

  // R12: cause bus idle when not written
  a_r12_cause_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !causeWrite |-> (causeCode == '0));

  // R10: cause write comes with EPC save and handler redirect
  a_r10_trap_redirects: assert property (@(posedge clk) disable iff (rst)
    causeWrite |-> (epcWrite && pcWrite && pcSrc == 2'd3));

  // R10: a trap step is followed by fetch
  a_r10_trap_then_fetch: assert property (@(posedge clk) disable iff (rst)
    epcWrite |=> irLoad);

  // R3: decode follows fetch
  a_r3_decode_after_fetch: assert property (@(posedge clk) disable iff (rst)
    irLoad |=> abLoad);

  // R11: overflow in the register execute step diverts to the overflow trap
  a_r11_overflow_trap: assert property (@(posedge clk) disable iff (rst)
    (aluOp == 2'd3 && aluOverflow) |=>
      (epcWrite && causeCode == CAUSE_W'(CAUSE_OVF) && !regWrite));

  // R6: no overflow lets the register result be written to rd
  a_r6_rtype_writeback: assert property (@(posedge clk) disable iff (rst)
    (aluOp == 2'd3 && !aluOverflow) |=> (regWrite && regDst));

  // R5: memory read and write never together
  a_r5_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(memRead && memWrite));

endmodule

bind mcycle_ctrl mcycle_ctrl_chk u_chk (.*);

// File: tb/mcycle_ctrl_test.sv
module mcycle_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  opcode = 6'h00;
  logic        aluOverflow = 1'b0;
  logic        aluEqual = 1'b0;
  logic        pcWrite, irLoad, abLoad, iord, memRead, memWrite;
  logic        regWrite, regDst, memToReg, aluSrcA, epcWrite, causeWrite;
  logic [1:0]  pcSrc, aluOp;
  logic [2:0]  aluSrcB;
  logic [4:0]  causeCode;
  logic [31:0] trapVector;

  always #5 clk = ~clk;

  mcycle_ctrl uut (
    .clk(clk), .rst(rst), .opcode(opcode), .aluOverflow(aluOverflow),
    .aluEqual(aluEqual), .pcWrite(pcWrite), .pcSrc(pcSrc), .irLoad(irLoad),
    .abLoad(abLoad), .iord(iord), .memRead(memRead), .memWrite(memWrite),
    .regWrite(regWrite), .regDst(regDst), .memToReg(memToReg),
    .aluSrcA(aluSrcA), .aluSrcB(aluSrcB), .aluOp(aluOp), .epcWrite(epcWrite),
    .causeWrite(causeWrite), .causeCode(causeCode), .trapVector(trapVector)
  );

  typedef struct packed {
    logic       pcWrite;
    logic [1:0] pcSrc;
    logic       irLoad, abLoad, iord, memRead, memWrite;
    logic       regWrite, regDst, memToReg, aluSrcA;
    logic [2:0] aluSrcB;
    logic [1:0] aluOp;
    logic       epcWrite, causeWrite;
    logic [4:0] causeCode;
  } outs_t;

  typedef enum {K_FETCH, K_DECODE, K_MEMADDR, K_LOADRD, K_LOADWB, K_STORE,
                K_REXEC, K_RWB, K_ORIEXEC, K_ORIWB, K_BRANCH, K_JUMP,
                K_TRAPU, K_TRAPO} step_t;

  outs_t act;
  assign act = {pcWrite, pcSrc, irLoad, abLoad, iord, memRead, memWrite,
                regWrite, regDst, memToReg, aluSrcA, aluSrcB, aluOp,
                epcWrite, causeWrite, causeCode};

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  outs_t expQ[$];
  string reqQ[$];
  int    pushed;

  function automatic outs_t expect_step(step_t k, logic eq);
    outs_t e = '0;
    case (k)
      K_FETCH:   begin e.memRead = 1; e.irLoad = 1; e.pcWrite = 1; e.aluSrcB = 3'd1; end
      K_DECODE:  begin e.abLoad = 1; e.aluSrcB = 3'd3; end
      K_MEMADDR: begin e.aluSrcA = 1; e.aluSrcB = 3'd2; end
      K_LOADRD:  begin e.memRead = 1; e.iord = 1; end
      K_LOADWB:  begin e.regWrite = 1; e.memToReg = 1; end
      K_STORE:   begin e.memWrite = 1; e.iord = 1; end
      K_REXEC:   begin e.aluSrcA = 1; e.aluOp = 2'd3; end
      K_RWB:     begin e.regWrite = 1; e.regDst = 1; end
      K_ORIEXEC: begin e.aluSrcA = 1; e.aluSrcB = 3'd4; e.aluOp = 2'd2; end
      K_ORIWB:   e.regWrite = 1;
      K_BRANCH:  begin e.aluSrcA = 1; e.aluOp = 2'd1; e.pcSrc = 2'd1; e.pcWrite = eq; end
      K_JUMP:    begin e.pcWrite = 1; e.pcSrc = 2'd2; end
      K_TRAPU, K_TRAPO: begin
        e.aluSrcB = 3'd1; e.aluOp = 2'd1; e.epcWrite = 1; e.causeWrite = 1;
        e.pcWrite = 1; e.pcSrc = 2'd3;
        e.causeCode = (k == K_TRAPO) ? 5'd12 : 5'd10;
      end
      default: e = '0;
    endcase
    return e;
  endfunction

  task automatic push(step_t k, string req);
    expQ.push_back(expect_step(k, aluEqual));
    reqQ.push_back(req);
    pushed++;
  endtask

  // driver: called at posedge+1 while the controller sits in fetch
  task automatic runInstr(logic [5:0] op, logic ovf, logic eq);
    opcode = op; aluOverflow = ovf; aluEqual = eq;
    pushed = 0;
    push(K_FETCH, "R2");
    push(K_DECODE, "R3");
    case (op)
      6'h23: begin push(K_MEMADDR, "R4"); push(K_LOADRD, "R4"); push(K_LOADWB, "R4"); end
      6'h2B: begin push(K_MEMADDR, "R5"); push(K_STORE, "R5"); end
      6'h00: begin
        push(K_REXEC, "R6");
        if (ovf) push(K_TRAPO, "R11"); else push(K_RWB, "R6");
      end
      6'h0D: begin push(K_ORIEXEC, "R7"); push(K_ORIWB, "R7"); end
      6'h04: push(K_BRANCH, "R8");
      6'h02: push(K_JUMP, "R9");
      default: push(K_TRAPU, "R10");
    endcase
    repeat (pushed) @(posedge clk);
    #1;
  endtask

  // monitor: compares mid-cycle
  outs_t mExp;
  string mReq;
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      mExp = expQ.pop_front();
      mReq = reqQ.pop_front();
      checks++;
      if (act !== mExp) begin
        errors++;
        $display("FAIL %s strobes got %h exp %h", mReq, act, mExp);
      end
      if (mExp.epcWrite) begin
        checks++;
        if (trapVector !== 32'h8000_0080) begin
          errors++;
          $display("FAIL R13 trapVector got %h exp %h", trapVector, 32'h8000_0080);
        end
      end
    end
  end

  task automatic checkFetchNow(string req);
    checks++;
    if (act !== expect_step(K_FETCH, 1'b0)) begin
      errors++;
      $display("FAIL %s reset state got %h exp %h", req, act, expect_step(K_FETCH, 1'b0));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkFetchNow("R1");
    rst = 1'b0;
    runInstr(6'h23, 1'b0, 1'b0);   // load
    runInstr(6'h2B, 1'b0, 1'b0);   // store
    runInstr(6'h00, 1'b0, 1'b0);   // register op, no overflow
    runInstr(6'h00, 1'b1, 1'b0);   // register op, overflow trap
    runInstr(6'h0D, 1'b0, 1'b0);   // OR immediate
    runInstr(6'h04, 1'b0, 1'b1);   // branch taken
    runInstr(6'h04, 1'b1, 1'b0);   // branch not taken, overflow ignored (R11)
    runInstr(6'h02, 1'b0, 1'b0);   // jump
    runInstr(6'h3F, 1'b0, 1'b0);   // undefined opcode
    runInstr(6'h01, 1'b1, 1'b1);   // undefined opcode, flags ignored
    runInstr(6'h23, 1'b1, 1'b1);   // load with overflow high: ignored (R11)
    runInstr(6'h0D, 1'b1, 1'b0);   // OR immediate with overflow high (R11)
    // reset in the middle of a load (R1)
    opcode = 6'h23; aluOverflow = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b1;
    @(posedge clk);
    #1;
    checkFetchNow("R1");
    rst = 1'b0;
    runInstr(6'h2B, 1'b0, 1'b0);
    runInstr(6'h00, 1'b1, 1'b1);
    runInstr(6'h00, 1'b0, 1'b0);
    repeat (2) @(posedge clk);
    #1;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule